// File: doc/BRIEF.md
# Synchronized Clock Stop and Power-Down Gate

This block takes eight free-running clock groups and passes each one to an output. Three active-low power-management pins decide whether each output runs or is held low. The pins are a CPU-side stop, a PCI-side stop and a power-down request. Each pin acts on its own set of groups, and some groups are exempt from some pins.

Every request that reaches a group first passes through a synchronizer clocked on that group's falling edge. The group's enable can therefore change only while its clock is low. The output is the clock ANDed with that enable, so an output never shows a shortened high pulse and never stops at a high level.

A small power sequencer runs on the reference group's clock. It has three states:
- `PWR_OFF`: oscillator and PLLs are modelled as shut down, and all enables are cleared.
- `PWR_RELOCK`: a fixed wait that models PLL relock.
- `PWR_RUN`: clocks are allowed.

Its transitions are:
- `PWR_OFF` goes to `PWR_RELOCK` when the synchronized power-down pin reads high.
- `PWR_RELOCK` goes to `PWR_RUN` after `RELOCK_CYCLES` reference cycles, or back to `PWR_OFF` if power-down returns.
- `PWR_RUN` goes to `PWR_OFF` when power-down is asserted.

Reset puts the sequencer in `PWR_OFF`.

Top module: `clkstop_ctrl`

## Requirements
- R1: Group bit order on `clk_grp_i` and `clk_grp_o` is: bit 0 CPU, bit 1 fixed 66 MHz, bit 2 half-CPU, bit 3 PCI, bit 4 free-running PCI, bit 5 I/O APIC, bit 6 48 MHz, bit 7 reference. Bit 7 also clocks the power sequencer. With all three control pins high and relock complete, every output follows its input clock and `osc_off_o` is low.
- R2: While `cpu_stop_n` is low, outputs 0 and 1 are held low and all other outputs keep running. Raising the pin restores outputs 0 and 1.
- R3: Output 2 (half-CPU) keeps running whatever the level of `cpu_stop_n`.
- R4: While `pci_stop_n` is low, output 3 is held low. Output 4 (free-running PCI) and all other groups not under CPU stop keep running.
- R5: While `pwr_down_n` is low, all eight outputs are held low whatever the two stop pins do, and `osc_off_o` is high.
- R6: After `pwr_down_n` rises, `osc_off_o` falls as relock starts. `PWR_RUN` is entered only from `PWR_RELOCK`, after exactly `RELOCK_CYCLES` reference cycles there. The outputs stay low for that whole wait and then resume.
- R7: Every high pulse on an output lasts a full high phase of its input clock, including across stops, restarts and power cycles.
- R8: While `rst_n` is low, all outputs are low and `osc_off_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_grp_i | input | 8 | Free-running clock per group (order in R1) |
| cpu_stop_n | input | 1 | Active-low stop for CPU and fixed 66 MHz groups |
| pci_stop_n | input | 1 | Active-low stop for the PCI group |
| pwr_down_n | input | 1 | Active-low power-down request |
| clk_grp_o | output | 8 | Gated clock per group |
| osc_off_o | output | 1 | High while oscillator and PLLs are modelled as off |

## Verification
A group enable stuck at the wrong value appears at the ports within two falling edges of that group's clock. It shows as an output that is flat where its source toggles, or one that toggles where it must stay low. A wrong mask shows as the wrong group reacting to a stop pin.

A sequencer that leaves `PWR_RELOCK` early or late moves the first pulse after power-up earlier or later by whole reference cycles. An early exit shows as pulses inside the window where all outputs must still be low.

An enable that changes while its clock is high leaves a pulse shorter than that clock's high phase. A width monitor on every output catches this at the pulse's falling edge.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;

    localparam int NUM_GRP = 8;

    localparam int GRP_CPU     = 0;
    localparam int GRP_FIX66   = 1;
    localparam int GRP_HALF    = 2;
    localparam int GRP_PCI     = 3;
    localparam int GRP_PCIFREE = 4;
    localparam int GRP_APIC    = 5;
    localparam int GRP_USB     = 6;
    localparam int GRP_REF     = 7;

    // Groups silenced by each stop pin; all other groups are exempt from that pin.
    localparam logic [NUM_GRP-1:0] CPU_STOP_MASK = NUM_GRP'((1 << GRP_CPU) | (1 << GRP_FIX66));
    localparam logic [NUM_GRP-1:0] PCI_STOP_MASK = NUM_GRP'(1 << GRP_PCI);

    typedef enum logic [1:0] {
        PWR_OFF    = 2'd0,
        PWR_RELOCK = 2'd1,
        PWR_RUN    = 2'd2
    } pwr_state_e;

endpackage

// File: rtl/clkstop_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer. FALL_EDGE picks the clock edge it samples on.
module clkstop_sync #(
    parameter int STAGES    = 2,
    parameter bit FALL_EDGE = 1'b0
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain;

    generate
        if (FALL_EDGE) begin : g_fall
            always_ff @(negedge clk_i or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d_i};
            end
        end else begin : g_rise
            always_ff @(posedge clk_i or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];

endmodule

// File: rtl/clkstop_pwrseq.sv
`timescale 1ns/1ps
// Power sequencer in the reference clock domain: off, relock wait, run.
module clkstop_pwrseq
    import clkstop_pkg::*;
#(
    parameter int RELOCK_CYCLES = 16,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk_i,
    input  logic       rst_n,
    input  logic       pwr_down_n_i,
    output logic       run_o,
    output logic       osc_off_o,
    output pwr_state_e state_o
);

    localparam int CW = $clog2(RELOCK_CYCLES + 1);

    logic          pwr_up_s;
    pwr_state_e    state_q, state_nxt;
    logic [CW-1:0] relock_cnt;
    logic          relock_done;

    clkstop_sync #(
        .STAGES   (SYNC_STAGES),
        .FALL_EDGE(1'b0)
    ) u_pwr_sync (
        .clk_i(clk_i),
        .rst_n(rst_n),
        .d_i  (pwr_down_n_i),
        .q_o  (pwr_up_s)
    );

    assign relock_done = (relock_cnt == CW'(RELOCK_CYCLES - 1));

    // State register
    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) state_q <= PWR_OFF;
        else        state_q <= state_nxt;
    end

    // Transitions
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            PWR_OFF:    if (pwr_up_s) state_nxt = PWR_RELOCK;
            PWR_RELOCK: begin
                if (!pwr_up_s)        state_nxt = PWR_OFF;
                else if (relock_done) state_nxt = PWR_RUN;
            end
            PWR_RUN:    if (!pwr_up_s) state_nxt = PWR_OFF;
            default:    state_nxt = PWR_OFF;
        endcase
    end

    // Relock wait counter, cleared outside the relock state
    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n)                     relock_cnt <= '0;
        else if (state_q != PWR_RELOCK) relock_cnt <= '0;
        else                            relock_cnt <= relock_cnt + 1'b1;
    end

    // Registered outputs, so the group enables see no decode glitches
    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) begin
            run_o     <= 1'b0;
            osc_off_o <= 1'b1;
        end else begin
            run_o     <= (state_nxt == PWR_RUN);
            osc_off_o <= (state_nxt == PWR_OFF);
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/clkstop_gate.sv
`timescale 1ns/1ps
// One clock group: falling-edge synchronized enable ANDed with the clock.
module clkstop_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic req_i,
    output logic en_o,
    output logic clk_o
);

    clkstop_sync #(
        .STAGES   (SYNC_STAGES),
        .FALL_EDGE(1'b1)
    ) u_en_sync (
        .clk_i(clk_i),
        .rst_n(rst_n),
        .d_i  (req_i),
        .q_o  (en_o)
    );

    // The enable moves only while clk_i is low, so the AND cannot shorten a high phase.
    assign clk_o = clk_i & en_o;

endmodule

// File: rtl/clkstop_ctrl.sv
`timescale 1ns/1ps
module clkstop_ctrl
    import clkstop_pkg::*;
#(
    parameter int RELOCK_CYCLES = 16,
    parameter int SYNC_STAGES   = 2
) (
    input  logic               rst_n,
    input  logic [NUM_GRP-1:0] clk_grp_i,
    input  logic               cpu_stop_n,
    input  logic               pci_stop_n,
    input  logic               pwr_down_n,
    output logic [NUM_GRP-1:0] clk_grp_o,
    output logic               osc_off_o
);

    logic               run_ok;
    pwr_state_e         pwr_state;
    logic [NUM_GRP-1:0] grp_req;
    logic [NUM_GRP-1:0] grp_en;

    clkstop_pwrseq #(
        .RELOCK_CYCLES(RELOCK_CYCLES),
        .SYNC_STAGES  (SYNC_STAGES)
    ) u_pwrseq (
        .clk_i       (clk_grp_i[GRP_REF]),
        .rst_n       (rst_n),
        .pwr_down_n_i(pwr_down_n),
        .run_o       (run_ok),
        .osc_off_o   (osc_off_o),
        .state_o     (pwr_state)
    );

    generate
        for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
            // Power-down (through run_ok) overrides everything; each stop pin only hits its masked groups.
            assign grp_req[g] = run_ok
                              & (cpu_stop_n | ~CPU_STOP_MASK[g])
                              & (pci_stop_n | ~PCI_STOP_MASK[g]);

            clkstop_gate #(
                .SYNC_STAGES(SYNC_STAGES)
            ) u_gate (
                .clk_i(clk_grp_i[g]),
                .rst_n(rst_n),
                .req_i(grp_req[g]),
                .en_o (grp_en[g]),
                .clk_o(clk_grp_o[g])
            );
        end
    endgenerate

endmodule

// File: rtl/clkstop_ctrl_chk.sv
`timescale 1ns/1ps
module clkstop_ctrl_chk
    import clkstop_pkg::*;
#(
    parameter int RELOCK_CYCLES = 16,
    parameter int SYNC_STAGES   = 2
) (
    input logic               rst_n,
    input logic [NUM_GRP-1:0] clk_grp_i,
    input logic               cpu_stop_n,
    input logic               pci_stop_n,
    input logic               pwr_down_n,
    input logic               osc_off_o,
    input logic               run_ok,
    input pwr_state_e         pwr_state,
    input logic [NUM_GRP-1:0] grp_en
);

    int pd_low_cnt, relock_len, cpu_low_cnt, pci_low_cnt, half_run_cnt, pcif_run_cnt;

    always_ff @(posedge clk_grp_i[GRP_REF] or negedge rst_n) begin
        if (!rst_n) begin
            pd_low_cnt <= 0;
            relock_len <= 0;
        end else begin
            pd_low_cnt <= pwr_down_n ? 0 : ((pd_low_cnt < 255) ? pd_low_cnt + 1 : pd_low_cnt);
            relock_len <= (pwr_state == PWR_RELOCK) ? relock_len + 1 : 0;
        end
    end

    always_ff @(negedge clk_grp_i[GRP_CPU] or negedge rst_n) begin
        if (!rst_n) cpu_low_cnt <= 0;
        else        cpu_low_cnt <= cpu_stop_n ? 0 : ((cpu_low_cnt < 255) ? cpu_low_cnt + 1 : cpu_low_cnt);
    end

    always_ff @(negedge clk_grp_i[GRP_PCI] or negedge rst_n) begin
        if (!rst_n) pci_low_cnt <= 0;
        else        pci_low_cnt <= pci_stop_n ? 0 : ((pci_low_cnt < 255) ? pci_low_cnt + 1 : pci_low_cnt);
    end

    always_ff @(negedge clk_grp_i[GRP_HALF] or negedge rst_n) begin
        if (!rst_n) half_run_cnt <= 0;
        else        half_run_cnt <= !run_ok ? 0 : ((half_run_cnt < 255) ? half_run_cnt + 1 : half_run_cnt);
    end

    always_ff @(negedge clk_grp_i[GRP_PCIFREE] or negedge rst_n) begin
        if (!rst_n) pcif_run_cnt <= 0;
        else        pcif_run_cnt <= !run_ok ? 0 : ((pcif_run_cnt < 255) ? pcif_run_cnt + 1 : pcif_run_cnt);
    end

    AST_PWRDN_FLAGGED: assert property (@(posedge clk_grp_i[GRP_REF]) disable iff (!rst_n)
        (pd_low_cnt > SYNC_STAGES) |-> osc_off_o); // R5

    AST_RELOCK_LENGTH: assert property (@(posedge clk_grp_i[GRP_REF]) disable iff (!rst_n)
        (pwr_state == PWR_RUN && $past(pwr_state) == PWR_RELOCK) |-> (relock_len == RELOCK_CYCLES)); // R6

    AST_RUN_AFTER_RELOCK: assert property (@(posedge clk_grp_i[GRP_REF]) disable iff (!rst_n)
        $rose(run_ok) |-> ($past(pwr_state) == PWR_RELOCK)); // R6

    AST_CPU_STOP_GATES: assert property (@(negedge clk_grp_i[GRP_CPU]) disable iff (!rst_n)
        (cpu_low_cnt >= SYNC_STAGES) |-> !grp_en[GRP_CPU]); // R2

    AST_PCI_STOP_GATES: assert property (@(negedge clk_grp_i[GRP_PCI]) disable iff (!rst_n)
        (pci_low_cnt >= SYNC_STAGES) |-> !grp_en[GRP_PCI]); // R4

    AST_HALF_EXEMPT: assert property (@(negedge clk_grp_i[GRP_HALF]) disable iff (!rst_n)
        (half_run_cnt >= SYNC_STAGES) |-> grp_en[GRP_HALF]); // R3

    AST_PCIFREE_EXEMPT: assert property (@(negedge clk_grp_i[GRP_PCIFREE]) disable iff (!rst_n)
        (pcif_run_cnt >= SYNC_STAGES) |-> grp_en[GRP_PCIFREE]); // R4

endmodule

bind clkstop_ctrl clkstop_ctrl_chk #(
    .RELOCK_CYCLES(RELOCK_CYCLES),
    .SYNC_STAGES  (SYNC_STAGES)
) u_chk (
    .rst_n     (rst_n),
    .clk_grp_i (clk_grp_i),
    .cpu_stop_n(cpu_stop_n),
    .pci_stop_n(pci_stop_n),
    .pwr_down_n(pwr_down_n),
    .osc_off_o (osc_off_o),
    .run_ok    (run_ok),
    .pwr_state (pwr_state),
    .grp_en    (grp_en)
);

// File: tb/tb_clkstop_ctrl.sv
`timescale 1ns/1ps
module tb_clkstop_ctrl;

    localparam int RELOCK = 8;
    localparam int HALF_NS [8] = '{5, 8, 10, 20, 20, 40, 11, 10};

    logic clk = 1'b0;          // 50 MHz, reference group
    logic c_cpu = 1'b0, c_f66 = 1'b0, c_half = 1'b0, c_pci = 1'b0;
    logic c_pcif = 1'b0, c_apic = 1'b0, c_usb = 1'b0;

    always #10 clk    = ~clk;
    always #5  c_cpu  = ~c_cpu;
    always #8  c_f66  = ~c_f66;
    always #10 c_half = ~c_half;
    always #20 c_pci  = ~c_pci;
    always #20 c_pcif = ~c_pcif;
    always #40 c_apic = ~c_apic;
    always #11 c_usb  = ~c_usb;

    wire [7:0] clk_in = {clk, c_usb, c_apic, c_pcif, c_pci, c_half, c_f66, c_cpu};

    logic       rst_n, cpu_n, pci_n, pwr_n;
    logic [7:0] clk_out;
    logic       osc_off;

    clkstop_ctrl #(.RELOCK_CYCLES(RELOCK), .SYNC_STAGES(2)) dut (
        .rst_n     (rst_n),
        .clk_grp_i (clk_in),
        .cpu_stop_n(cpu_n),
        .pci_stop_n(pci_n),
        .pwr_down_n(pwr_n),
        .clk_grp_o (clk_out),
        .osc_off_o (osc_off)
    );

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_sim();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    // Pulse-width monitor on each output (R7)
    realtime t_rise [8];
    bit      seen   [8];
    int      runts  [8];
    for (genvar g = 0; g < 8; g++) begin : g_mon
        initial begin seen[g] = 1'b0; runts[g] = 0; end
        always @(posedge clk_out[g]) begin t_rise[g] = $realtime; seen[g] = 1'b1; end
        always @(negedge clk_out[g])
            if (seen[g] && ($realtime - t_rise[g] < HALF_NS[g] - 0.01)) runts[g]++;
    end

    // Expected enables from the requirements: bits 0,1 under CPU stop, bit 3 under PCI stop.
    function automatic logic [7:0] exp_en(input bit cpu, input bit pci, input bit pwr);
        logic [7:0] e;
        e = 8'hFF;
        if (!pwr) return 8'h00;
        if (!cpu) begin e[0] = 1'b0; e[1] = 1'b0; end
        if (!pci) e[3] = 1'b0;
        return e;
    endfunction

    task automatic observe(input logic [7:0] exp, input int win, input string req);
        int mism [8];
        for (int g = 0; g < 8; g++) mism[g] = 0;
        repeat (win) begin
            #1;
            for (int g = 0; g < 8; g++)
                if (clk_out[g] !== (clk_in[g] & exp[g])) mism[g]++;
        end
        for (int g = 0; g < 8; g++)
            chk(mism[g] == 0, req, $sformatf("group %0d mismatched samples", g), mism[g], 0);
    endtask

    task automatic t_reset();
        #60;
        observe(8'h00, 30, "R8");
        chk(osc_off == 1'b1, "R8", "osc_off in reset", int'(osc_off), 1);
        rst_n = 1'b1;
        #600;
    endtask

    task automatic t_all_run();
        observe(8'hFF, 200, "R1");
        chk(osc_off == 1'b0, "R1", "osc_off running", int'(osc_off), 0);
    endtask

    task automatic t_cpu_stop();
        cpu_n = 1'b0;
        #300;
        observe(exp_en(1'b0, 1'b1, 1'b1), 200, "R2");
        observe(exp_en(1'b0, 1'b1, 1'b1), 100, "R3");
        cpu_n = 1'b1;
        #300;
        observe(8'hFF, 100, "R2");
    endtask

    task automatic t_pci_stop();
        pci_n = 1'b0;
        #300;
        observe(exp_en(1'b1, 1'b0, 1'b1), 200, "R4");
        pci_n = 1'b1;
        #300;
        observe(8'hFF, 100, "R4");
    endtask

    task automatic t_both_stop();
        cpu_n = 1'b0;
        pci_n = 1'b0;
        #300;
        observe(exp_en(1'b0, 1'b0, 1'b1), 200, "R2");
        cpu_n = 1'b1;
        pci_n = 1'b1;
        #300;
    endtask

    task automatic t_powerdown();
        pwr_n = 1'b0;
        #300;
        observe(8'h00, 200, "R5");
        chk(osc_off == 1'b1, "R5", "osc_off in power-down", int'(osc_off), 1);
        cpu_n = 1'b0;
        pci_n = 1'b0;
        #100;
        observe(8'h00, 100, "R5");
        cpu_n = 1'b1;
        pci_n = 1'b1;
    endtask

    task automatic t_relock();
        pwr_n = 1'b1;
        #5;
        // Two sync stages plus RELOCK cycles keep every output low well past 180 ns.
        observe(8'h00, 175, "R6");
        chk(osc_off == 1'b0, "R6", "osc_off during relock", int'(osc_off), 0);
        #420;
        observe(8'hFF, 200, "R6");
    endtask

    task automatic t_stress();
        repeat (40) begin
            #7  cpu_n = ~cpu_n;
            #13 pci_n = ~pci_n;
            #3;
        end
        pwr_n = 1'b0;
        #57;
        pwr_n = 1'b1;
        #31;
        cpu_n = 1'b1;
        pci_n = 1'b1;
        #700;
        observe(8'hFF, 100, "R7");
        for (int g = 0; g < 8; g++)
            chk(runts[g] == 0, "R7", $sformatf("group %0d short pulses", g), runts[g], 0);
    endtask

    initial begin
        rst_n = 1'b0;
        cpu_n = 1'b1;
        pci_n = 1'b1;
        pwr_n = 1'b1;
        #0.5;
        t_reset();
        t_all_run();
        t_cpu_stop();
        t_pci_stop();
        t_both_stop();
        t_powerdown();
        t_relock();
        t_stress();
        finish_sim();
    end

    initial begin
        #100000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_sim();
    end

endmodule